// File: doc/BRIEF.md
# Precision Time Message Timestamp Capture Unit

This block sits beside one network port and records the system time at which time-synchronisation event messages cross the port. A message detector outside the block pulses a transmit or receive strobe with a message-kind code. The block then decides whether this message is one it should timestamp. That depends on the kind (Sync or Delay_Req) and on whether the channel runs as a clock master or a clock slave. If it should, the block copies the 64-bit system time into either a transmit capture register or a receive capture register.

When the frame later ends without error, the block latches that capture and raises a sticky per-kind event flag. While the flag is up, the capture register is frozen. Firmware reads the captured time, for example to build a Follow_Up message, and then writes 1 to the flag to re-arm capture. An errored frame raises no flag, so the next message of that kind overwrites the capture. A control bit can disable the freeze, so that every matching message is captured.

Firmware reaches the block through a small word-wide register port with a write strobe and a combinational read. Word map: 0 control, 1 events, 2/3 transmit capture low/high, 4/5 receive capture low/high.

Top module: `ptp_snap_unit`

## Requirements
- R1: With control bit 0 (master) set, a transmit strobe of kind Sync (code 0) captures into the transmit register, and a receive strobe of kind Delay_Req (code 1) captures into the receive register.
- R2: With control bit 0 clear (slave), a receive strobe of kind Sync captures into the receive register, and a transmit strobe of kind Delay_Req captures into the transmit register.
- R3: The captured value equals `sys_time` in the cycle the strobe is high, and it can be read from the next cycle on.
- R4: When a captured frame ends with a done strobe and no error, an event flag sets in word 1: bit 0 for Sync and bit 1 for Delay_Req.
- R5: A done strobe with the error bit set raises no flag and leaves the capture unlocked, so a later message of that kind overwrites it.
- R6: While a kind's event flag is set and control bit 1 is clear, further messages of that kind do not change the capture register.
- R7: Writing 1 to an event bit clears it. Writing 0 leaves it unchanged.
- R8: With control bit 1 (lock inhibit) set, every matching message is captured, and the event flag still sets on a clean end.
- R9: Follow_Up (code 2) and other kinds, and Sync or Delay_Req seen on the direction that does not match the role, cause no capture and no event.
- R10: If a clear write and a new event for the same bit fall in the same cycle, the bit stays set.
- R11: Reads have no side effects, and writes to the capture words are ignored.
- R12: After reset, control, events and both captures read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_time | input | 64 | Current system time |
| tx_det | input | 1 | Transmit message detected (one-cycle pulse) |
| tx_kind | input | 2 | Kind of transmit message: 0 Sync, 1 Delay_Req, 2 Follow_Up, 3 other |
| tx_done | input | 1 | Transmit frame ended |
| tx_err | input | 1 | Transmit frame ended with an error (valid with tx_done) |
| rx_det | input | 1 | Receive message detected (one-cycle pulse) |
| rx_kind | input | 2 | Kind of receive message, same codes as tx_kind |
| rx_done | input | 1 | Receive frame ended |
| rx_err | input | 1 | Receive frame ended with an error (valid with rx_done) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |

## Verification
The in-line assertions check, on every cycle, that a capture takes the time of its strobe cycle, and that a frozen or non-matching capture holds its value. They also check that an event flag only appears after a clean frame end, that flags are sticky unless cleared, and that a same-cycle set beats a clear. The directed scenarios are needed for the end-to-end behaviour. They cover the role and kind routing for both directions, the overwrite after an errored frame, the 0-write versus 1-write on events, the inhibit mode, and the reset and read-back values seen through the register port.

// File: rtl/ptp_snap_pkg.sv
package ptp_snap_pkg;

    localparam int REG_W  = 32;
    localparam int TIME_W = 2 * REG_W;
    localparam int ADDR_W = 3;
    localparam int N_DIR  = 2;       // 0 = transmit, 1 = receive

    typedef enum logic [1:0] {
        KIND_SYNC  = 2'd0,
        KIND_DREQ  = 2'd1,
        KIND_FUP   = 2'd2,
        KIND_OTHER = 2'd3
    } msg_kind_e;

    localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_EVENT = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_TX_LO = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_TX_HI = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_RX_LO = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_RX_HI = 3'd5;

    typedef struct packed {
        logic inhibit;   // bit 1
        logic master;    // bit 0
    } ctrl_t;

    typedef struct packed {
        logic dreq;      // bit 1
        logic sync;      // bit 0
    } event_t;

    // Kind of message a direction timestamps for the given role
    function automatic msg_kind_e slot_kind(input logic master, input logic is_tx);
        if (is_tx) return master ? KIND_SYNC : KIND_DREQ;
        else       return master ? KIND_DREQ : KIND_SYNC;
    endfunction

endpackage

// File: rtl/ptp_snap_slot.sv
module ptp_snap_slot
    import ptp_snap_pkg::*;
#(
    parameter int W = TIME_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap_i,
    input  logic         done_i,
    input  logic         err_i,
    input  logic [W-1:0] time_i,
    output logic [W-1:0] snap_o,
    output logic         lock_o
);

    logic pending_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_o    <= '0;
            pending_q <= 1'b0;
        end else begin
            if (done_i) pending_q <= 1'b0;
            if (cap_i) begin
                snap_o    <= time_i;
                pending_q <= 1'b1;
            end
        end
    end

    // clean end of a frame that was captured
    assign lock_o = done_i && pending_q && !err_i;

    AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (rst)
        cap_i |=> (snap_o == $past(time_i)));                  // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !cap_i |=> $stable(snap_o));                           // R6

endmodule

// File: rtl/ptp_snap_regs.sv
module ptp_snap_regs
    import ptp_snap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic              set_sync_i,
    input  logic              set_dreq_i,
    input  logic [TIME_W-1:0] tx_snap_i,
    input  logic [TIME_W-1:0] rx_snap_i,
    output ctrl_t             ctrl_o,
    output event_t            ev_o,
    output logic [REG_W-1:0]  rdata_o
);

    logic   wr_ctrl, wr_ev;
    event_t clr;
    logic   unused_wdata;

    assign wr_ctrl      = wr_i && (addr_i == ADR_CTRL);
    assign wr_ev        = wr_i && (addr_i == ADR_EVENT);
    assign clr.sync     = wr_ev && wdata_i[0];
    assign clr.dreq     = wr_ev && wdata_i[1];
    assign unused_wdata = ^wdata_i[REG_W-1:2];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_o <= '0;
            ev_o   <= '0;
        end else begin
            if (wr_ctrl) ctrl_o <= ctrl_t'(wdata_i[1:0]);
            // set has priority over a same-cycle clear
            ev_o.sync <= set_sync_i | (ev_o.sync & ~clr.sync);
            ev_o.dreq <= set_dreq_i | (ev_o.dreq & ~clr.dreq);
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADR_CTRL:  rdata_o = {{(REG_W-2){1'b0}}, ctrl_o};
            ADR_EVENT: rdata_o = {{(REG_W-2){1'b0}}, ev_o};
            ADR_TX_LO: rdata_o = tx_snap_i[REG_W-1:0];
            ADR_TX_HI: rdata_o = tx_snap_i[TIME_W-1:REG_W];
            ADR_RX_LO: rdata_o = rx_snap_i[REG_W-1:0];
            ADR_RX_HI: rdata_o = rx_snap_i[TIME_W-1:REG_W];
            default:   rdata_o = '0;
        endcase
    end

    AST_EV_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ev_o.sync && !(wr_i && addr_i == ADR_EVENT && wdata_i[0])) |=> ev_o.sync); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set_dreq_i |=> ev_o.dreq);                                                  // R10

endmodule

// File: rtl/ptp_snap_unit.sv
module ptp_snap_unit
    import ptp_snap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [TIME_W-1:0] sys_time,
    input  logic              tx_det,
    input  logic [1:0]        tx_kind,
    input  logic              tx_done,
    input  logic              tx_err,
    input  logic              rx_det,
    input  logic [1:0]        rx_kind,
    input  logic              rx_done,
    input  logic              rx_err,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata
);

    ctrl_t       ctrl;
    event_t      ev;
    logic        det  [N_DIR];
    msg_kind_e   kind [N_DIR];
    logic        done [N_DIR];
    logic        err  [N_DIR];
    msg_kind_e   want [N_DIR];
    logic        blocked [N_DIR];
    logic        cap  [N_DIR];
    logic        lock [N_DIR];
    logic [TIME_W-1:0] snap [N_DIR];
    logic        set_sync, set_dreq;

    assign det[0]  = tx_det;   assign det[1]  = rx_det;
    assign kind[0] = msg_kind_e'(tx_kind);
    assign kind[1] = msg_kind_e'(rx_kind);
    assign done[0] = tx_done;  assign done[1] = rx_done;
    assign err[0]  = tx_err;   assign err[1]  = rx_err;

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        assign want[d]    = slot_kind(ctrl.master, d == 0);
        assign blocked[d] = !ctrl.inhibit && ((want[d] == KIND_SYNC) ? ev.sync : ev.dreq);
        assign cap[d]     = det[d] && (kind[d] == want[d]) && !blocked[d];

        ptp_snap_slot #(.W(TIME_W)) slot_i (
            .clk    (clk),
            .rst    (rst),
            .cap_i  (cap[d]),
            .done_i (done[d]),
            .err_i  (err[d]),
            .time_i (sys_time),
            .snap_o (snap[d]),
            .lock_o (lock[d])
        );
    end

    assign set_sync = (lock[0] && want[0] == KIND_SYNC) || (lock[1] && want[1] == KIND_SYNC);
    assign set_dreq = (lock[0] && want[0] == KIND_DREQ) || (lock[1] && want[1] == KIND_DREQ);

    ptp_snap_regs regs_i (
        .clk        (clk),
        .rst        (rst),
        .wr_i       (reg_wr),
        .addr_i     (reg_addr),
        .wdata_i    (reg_wdata),
        .set_sync_i (set_sync),
        .set_dreq_i (set_dreq),
        .tx_snap_i  (snap[0]),
        .rx_snap_i  (snap[1]),
        .ctrl_o     (ctrl),
        .ev_o       (ev),
        .rdata_o    (reg_rdata)
    );

    AST_EVENT_NEEDS_CLEAN_END: assert property (@(posedge clk) disable iff (rst)
        $rose(ev.sync) |-> $past((tx_done && !tx_err) || (rx_done && !rx_err)));   // R5
    AST_FUP_NO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (tx_det && tx_kind >= 2'd2) |=> $stable(snap[0]));                         // R9
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ctrl.master && !ctrl.inhibit && ev.sync) |=> $stable(snap[0]));           // R6

endmodule

// File: tb/ptp_snap_unit_tb.sv
module ptp_snap_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] sys_time = '0;
    logic        tx_det = 0, tx_done = 0, tx_err = 0;
    logic        rx_det = 0, rx_done = 0, rx_err = 0;
    logic [1:0]  tx_kind = 0, rx_kind = 0;
    logic        reg_wr = 0;
    logic [2:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    ptp_snap_unit dut_i (
        .clk(clk), .rst(rst), .sys_time(sys_time),
        .tx_det(tx_det), .tx_kind(tx_kind), .tx_done(tx_done), .tx_err(tx_err),
        .rx_det(rx_det), .rx_kind(rx_kind), .rx_done(rx_done), .rx_err(rx_err),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd64(input logic [2:0] lo, output logic [63:0] v);
        logic [31:0] l, h;
        rd(lo, l);
        rd(lo + 3'd1, h);
        v = {h, l};
    endtask

    // dir 0 = transmit, 1 = receive; detect, then frame end one cycle later
    task automatic send(input bit dir, input logic [1:0] k, input logic [63:0] t, input bit e);
        @(negedge clk);
        sys_time = t;
        if (dir == 0) begin tx_det = 1; tx_kind = k; end
        else          begin rx_det = 1; rx_kind = k; end
        @(negedge clk);
        tx_det = 0; rx_det = 0;
        sys_time = ~t;
        if (dir == 0) begin tx_done = 1; tx_err = e; end
        else          begin rx_done = 1; rx_err = e; end
        @(negedge clk);
        tx_done = 0; tx_err = 0; rx_done = 0; rx_err = 0;
    endtask

    task automatic t_reset;
        logic [31:0] d; logic [63:0] v;
        rd(3'd0, d);  chk("R12 ctrl", d, 0);
        rd(3'd1, d);  chk("R12 event", d, 0);
        rd64(3'd2, v); chk("R12 tx snap", v, 0);
        rd64(3'd4, v); chk("R12 rx snap", v, 0);
    endtask

    task automatic t_slave_sync;
        logic [31:0] d; logic [63:0] v;
        send(1, 2'd0, 64'h1111_2222_3333_4444, 0);
        rd64(3'd4, v); chk("R2 R3 slave rx sync", v, 64'h1111_2222_3333_4444);
        rd(3'd1, d);  chk("R4 sync event", d, 1);
        rd64(3'd2, v); chk("R2 tx untouched", v, 0);
    endtask

    task automatic t_lockout;
        logic [31:0] d; logic [63:0] v;
        send(1, 2'd0, 64'h5555_6666_7777_8888, 0);
        rd64(3'd4, v); chk("R6 frozen", v, 64'h1111_2222_3333_4444);
        wr(3'd4, 32'hDEAD_BEEF);
        rd64(3'd4, v); chk("R11 write ignored", v, 64'h1111_2222_3333_4444);
        rd64(3'd4, v); chk("R11 reread", v, 64'h1111_2222_3333_4444);
        rd(3'd1, d);  chk("R11 event after reads", d, 1);
    endtask

    task automatic t_w1c;
        logic [31:0] d;
        wr(3'd1, 32'h0);
        rd(3'd1, d); chk("R7 write 0", d, 1);
        wr(3'd1, 32'h1);
        rd(3'd1, d); chk("R7 write 1", d, 0);
    endtask

    task automatic t_slave_dreq;
        logic [31:0] d; logic [63:0] v;
        send(0, 2'd1, 64'h0000_00AA_0000_00BB, 0);
        rd64(3'd2, v); chk("R2 slave tx dreq", v, 64'h0000_00AA_0000_00BB);
        rd(3'd1, d);  chk("R4 dreq event", d, 2);
        wr(3'd1, 32'h3);
    endtask

    task automatic t_error;
        logic [31:0] d; logic [63:0] v;
        send(1, 2'd0, 64'h0BAD_0000_0000_0001, 1);
        rd64(3'd4, v); chk("R5 errored capture", v, 64'h0BAD_0000_0000_0001);
        rd(3'd1, d);  chk("R5 no event", d, 0);
        send(1, 2'd0, 64'h600D_0000_0000_0002, 0);
        rd64(3'd4, v); chk("R5 overwrite", v, 64'h600D_0000_0000_0002);
        rd(3'd1, d);  chk("R5 event after clean", d, 1);
        wr(3'd1, 32'h3);
    endtask

    task automatic t_master;
        logic [31:0] d; logic [63:0] v;
        wr(3'd0, 32'h1);
        send(0, 2'd0, 64'hA000_0000_0000_0006, 0);
        rd64(3'd2, v); chk("R1 master tx sync", v, 64'hA000_0000_0000_0006);
        send(1, 2'd1, 64'hB000_0000_0000_0007, 0);
        rd64(3'd4, v); chk("R1 master rx dreq", v, 64'hB000_0000_0000_0007);
        rd(3'd1, d);  chk("R1 R4 both events", d, 3);
        wr(3'd1, 32'h3);
    endtask

    task automatic t_fup;
        logic [31:0] d; logic [63:0] v;
        send(0, 2'd2, 64'hC000_0000_0000_0008, 0);
        rd64(3'd2, v); chk("R9 follow_up tx", v, 64'hA000_0000_0000_0006);
        send(1, 2'd0, 64'hC000_0000_0000_0009, 0);
        rd64(3'd4, v); chk("R9 master rx sync", v, 64'hB000_0000_0000_0007);
        send(0, 2'd1, 64'hC000_0000_0000_000A, 0);
        rd64(3'd2, v); chk("R9 master tx dreq", v, 64'hA000_0000_0000_0006);
        rd(3'd1, d);  chk("R9 no event", d, 0);
    endtask

    task automatic t_inhibit;
        logic [31:0] d; logic [63:0] v;
        wr(3'd0, 32'h3);
        send(0, 2'd0, 64'hD000_0000_0000_0010, 0);
        send(0, 2'd0, 64'hD000_0000_0000_0011, 0);
        rd64(3'd2, v); chk("R8 second capture", v, 64'hD000_0000_0000_0011);
        rd(3'd1, d);  chk("R8 event still sets", d, 1);
    endtask

    task automatic t_collision;
        logic [31:0] d;
        // inhibit on, sync flag already set; new frame ends as flag is cleared
        @(negedge clk);
        sys_time = 64'hE0; tx_det = 1; tx_kind = 2'd0;
        @(negedge clk);
        tx_det = 0; tx_done = 1; tx_err = 0;
        reg_wr = 1; reg_addr = 3'd1; reg_wdata = 32'h1;
        @(negedge clk);
        tx_done = 0; reg_wr = 0; reg_wdata = 0;
        rd(3'd1, d); chk("R10 set wins", d, 1);
        wr(3'd1, 32'h1);
        rd(3'd1, d); chk("R10 later clear", d, 0);
        wr(3'd0, 32'h1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_slave_sync();
        t_lockout();
        t_w1c();
        t_slave_dreq();
        t_error();
        t_master();
        t_fup();
        t_inhibit();
        t_collision();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule